// File: doc/BRIEF.md
# Interrupt Status Aggregator with Mask and Write-One-to-Clear

This unit collects the interrupt sources of a serial bus controller and reduces them to one interrupt line. The sources are the transmit and receive FIFOs and the transaction engine. FIFO conditions arrive as levels and are mirrored into a raw status word. Transaction events arrive as one-cycle pulses and are held in sticky bits until software clears them.

Software reaches four word registers through simple read and write strobes at fixed byte offsets:

- an enable mask at 0x2C,
- the raw status at 0x30,
- the masked status at 0x34,
- a write-one-to-clear port at 0x38.

Only a sparse set of 32 bit positions is implemented. Every other bit reads zero and ignores writes. A build parameter decides whether the "transaction finished with no stop condition" source exists.

Top module: `irq_status_unit`

## Requirements
- R1: Raw status bit positions are fixed: tx empty 0, tx almost empty 1, tx full 2, tx overrun 3, rx empty 4, rx almost full 5, rx full 6, slave-read request 16, slave-read empty 17, slave-write request 18, master done 19, slave done 20, arbitration lost 24, bus error 25, master done with no stop 28.
- R2: Bits 0, 1, 2, 4, 5, 6 are levels. Each one equals the matching `src_lvl` bit one clock after it is sampled. Writes to the clear port do not change these bits.
- R3: Bits 3, 16 to 20, 24, 25 and 28 are sticky. A one-cycle high on the matching `src_evt` bit sets the bit at the next clock, and the bit stays set until it is cleared.
- R4: A write to offset 0x38 clears every sticky bit whose write-data bit is 1. Bits written 0 keep their value.
- R5: When an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R6: Only bits in 0x131F007F are implemented. Every other bit of raw, mask and masked reads zero, and events, levels or writes on those positions have no effect. Mask bits 31:29 always read zero.
- R7: With `HAS_NOSTOP_DONE` = 0, bit 28 is unimplemented: events on it are ignored, and mask writes read back as 0x031F007F.
- R8: A read of offset 0x34 returns raw status ANDed with the mask.
- R9: `irq` is high exactly when the masked status is nonzero.
- R10: Read data appears on `bus_rdata` in the cycle after `bus_rd`. Offset 0x38 and any unmapped offset read 0. Writes to 0x30 and 0x34 are ignored. Reset clears mask, raw status and read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_evt | input | 32 | Event pulses, one per sticky source |
| src_lvl | input | 32 | FIFO condition levels |
| irq | output | 1 | Combined interrupt |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:

- **Event and clear in the same cycle.** A design that let the clear win would silently lose an interrupt.
- **Clear aimed at a level bit.** A faulty design would drop a FIFO condition that is still present.
- **Events and mask writes on unimplemented or reserved positions.** A faulty design would let phantom bits reach `irq`.
- **Bit 28 in the variant without that source.** The bench checks that the bit stays inert when the parameter removes it.
- **Writes to the read-only offsets and reads of the clear port.** A sloppy decoder would corrupt state on the writes or return stale data on the reads.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [31:0] IMPL_ALL  = 32'h131F_007F;
  localparam logic [31:0] LVL_BITS  = 32'h0000_0077;
  localparam logic [31:0] RESV_KEEP = 32'h1FFF_FFFF;
  localparam int unsigned NOSTOP_POS = 28;

  function automatic logic [31:0] impl_bits(input bit has_nostop);
    logic [31:0] m;
    m = IMPL_ALL;
    if (!has_nostop) m[NOSTOP_POS] = 1'b0;
    return m;
  endfunction

  function automatic logic [31:0] sticky_bits(input bit has_nostop);
    return impl_bits(has_nostop) & ~LVL_BITS;
  endfunction
endpackage

// File: rtl/irq_raw_bank.sv
module irq_raw_bank #(
  parameter int unsigned W      = 32,
  parameter logic [W-1:0] IMPL  = '0,
  parameter logic [W-1:0] LEVEL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] clr,
  output logic [W-1:0] raw
);
  localparam logic [W-1:0] STICKY = IMPL & ~LEVEL;

  logic unused_inputs;
  assign unused_inputs = ^(evt & ~STICKY) ^ ^(lvl & ~(IMPL & LEVEL)) ^ ^(clr & ~STICKY);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (!IMPL[i]) begin : g_none
      assign raw[i] = 1'b0;
    end else if (LEVEL[i]) begin : g_level
      logic q;
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= lvl[i];
      end
      assign raw[i] = q;
    end else begin : g_sticky
      logic q;
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= evt[i] | (q & ~clr[i]);
      end
      assign raw[i] = q;
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned W     = 32,
  parameter logic [W-1:0] KEEP = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst)     mask <= '0;
    else if (we) mask <= wdata & KEEP;
  end
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port #(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] MASK_OFF = '0,
  parameter logic [ADDR_W-1:0] RAW_OFF  = '0,
  parameter logic [ADDR_W-1:0] MSKD_OFF = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      mask,
  input  logic [W-1:0]      raw,
  input  logic [W-1:0]      masked,
  output logic [W-1:0]      rdata
);
  logic [W-1:0] sel;

  always_comb begin
    unique case (addr)
      MASK_OFF: sel = mask;
      RAW_OFF:  sel = raw;
      MSKD_OFF: sel = masked;
      default:  sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= sel;
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_agg_pkg::*;
#(
  parameter bit          HAS_NOSTOP_DONE = 1'b1,
  parameter int unsigned ADDR_W          = 8,
  parameter logic [ADDR_W-1:0] MASK_OFF  = 8'h2C,
  parameter logic [ADDR_W-1:0] RAW_OFF   = 8'h30,
  parameter logic [ADDR_W-1:0] MSKD_OFF  = 8'h34,
  parameter logic [ADDR_W-1:0] CLR_OFF   = 8'h38
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       src_evt,
  input  logic [31:0]       src_lvl,
  output logic              irq
);
  localparam logic [31:0] IMPL   = impl_bits(HAS_NOSTOP_DONE);
  localparam logic [31:0] STICKY = sticky_bits(HAS_NOSTOP_DONE);
  localparam logic [31:0] KEEP   = IMPL & RESV_KEEP;

  logic        mask_we;
  logic        clr_we;
  logic [31:0] clr_vec;
  logic [31:0] raw_q;
  logic [31:0] mask_q;
  logic [31:0] masked;

  assign mask_we = bus_wr && (bus_addr == MASK_OFF);
  assign clr_we  = bus_wr && (bus_addr == CLR_OFF);
  assign clr_vec = clr_we ? (bus_wdata & STICKY) : '0;

  irq_raw_bank #(.W(WORD_W), .IMPL(IMPL), .LEVEL(LVL_BITS)) u_raw (
    .clk (clk),
    .rst (rst),
    .evt (src_evt),
    .lvl (src_lvl),
    .clr (clr_vec),
    .raw (raw_q)
  );

  irq_mask_reg #(.W(WORD_W), .KEEP(KEEP)) u_mask (
    .clk   (clk),
    .rst   (rst),
    .we    (mask_we),
    .wdata (bus_wdata),
    .mask  (mask_q)
  );

  assign masked = raw_q & mask_q;
  assign irq    = |masked;

  irq_read_port #(
    .W(WORD_W), .ADDR_W(ADDR_W),
    .MASK_OFF(MASK_OFF), .RAW_OFF(RAW_OFF), .MSKD_OFF(MSKD_OFF)
  ) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd     (bus_rd),
    .addr   (bus_addr),
    .mask   (mask_q),
    .raw    (raw_q),
    .masked (masked),
    .rdata  (bus_rdata)
  );
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk
  import irq_agg_pkg::*;
#(
  parameter bit          HAS_NOSTOP_DONE = 1'b1,
  parameter int unsigned ADDR_W          = 8,
  parameter logic [ADDR_W-1:0] MASK_OFF  = 8'h2C,
  parameter logic [ADDR_W-1:0] CLR_OFF   = 8'h38
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [31:0]       src_evt,
  input logic [31:0]       src_lvl,
  input logic              irq,
  input logic [31:0]       raw_q,
  input logic [31:0]       mask_q
);
  localparam logic [31:0] IMPL   = impl_bits(HAS_NOSTOP_DONE);
  localparam logic [31:0] STICKY = sticky_bits(HAS_NOSTOP_DONE);

  // R6
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((raw_q & ~IMPL) == 0) && (mask_q[31:29] == 3'b000));

  // R2
  lvl_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (raw_q & LVL_BITS) == $past(src_lvl & LVL_BITS));

  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == CLR_OFF) |=>
      ((raw_q & $past(raw_q & STICKY)) == $past(raw_q & STICKY)));

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ((src_evt & STICKY) != 0) |=>
      ((raw_q & $past(src_evt & STICKY)) == $past(src_evt & STICKY)));

  // R4
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == CLR_OFF) |=>
      ((raw_q & $past(bus_wdata & STICKY & ~src_evt)) == 0));

  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (((src_evt & STICKY & mask_q) != 0) && !(bus_wr && bus_addr == MASK_OFF)) |=> irq);

  // R10
  clr_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == CLR_OFF) |=> (bus_rdata == 0));
endmodule

bind irq_status_unit irq_status_unit_chk #(
  .HAS_NOSTOP_DONE(HAS_NOSTOP_DONE), .ADDR_W(ADDR_W),
  .MASK_OFF(MASK_OFF), .CLR_OFF(CLR_OFF)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_evt(src_evt),
  .src_lvl(src_lvl), .irq(irq), .raw_q(raw_q), .mask_q(mask_q)
);

// File: tb/irq_status_unit_test.sv
module irq_status_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_MASK = 8'h2C, A_RAW = 8'h30, A_MSKD = 8'h34, A_CLR = 8'h38;

  // fields: evt, lvl, mask, clr, exp_raw, exp_masked, exp_irq
  localparam int NV = 7;
  localparam logic [31:0] VEC [NV][7] = '{
    '{32'h0008_0000, 32'h0000_0000, 32'h0008_0000, 32'h0, 32'h0008_0000, 32'h0008_0000, 32'd1},
    '{32'h0300_0000, 32'h0000_0011, 32'h0000_0001, 32'h0100_0000, 32'h0200_0011, 32'h0000_0001, 32'd1},
    '{32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0, 32'h131F_0008, 32'h131F_0008, 32'd1},
    '{32'h0010_0008, 32'h0000_0066, 32'h0000_0000, 32'h0, 32'h0010_006E, 32'h0000_0000, 32'd0},
    '{32'h1000_0000, 32'h0000_0000, 32'h1000_0000, 32'h1000_0000, 32'h0, 32'h0, 32'd0},
    '{32'h00E0_FF80, 32'hFFFF_FF88, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0, 32'd0},
    '{32'h0000_0000, 32'h0000_0004, 32'h0000_0004, 32'h0000_0004, 32'h0000_0004, 32'h0000_0004, 32'd1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, src_evt = '0, src_lvl = '0;
  logic [31:0] rdata, rdata_nw;
  logic        irq, irq_nw;
  int          n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_unit uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata), .src_evt(src_evt), .src_lvl(src_lvl), .irq(irq)
  );

  irq_status_unit #(.HAS_NOSTOP_DONE(1'b0)) uut_nw (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_nw), .src_evt(src_evt), .src_lvl(src_lvl), .irq(irq_nw)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic pulse(input logic [31:0] e);
    @(negedge clk); src_evt = e;
    @(negedge clk); src_evt = '0;
  endtask

  task automatic wipe();
    src_lvl = '0;
    wr(A_CLR, 32'hFFFF_FFFF);
    wr(A_MASK, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check("R10 reset rdata", rdata, 32'h0);
    check("R9 reset irq", {31'b0, irq}, 32'h0);
    rd(A_RAW);  check("R10 reset raw", rdata, 32'h0);
    rd(A_MASK); check("R10 reset mask", rdata, 32'h0);

    // R1 R2 R3 R4 R6 R8 R9 vector walk
    for (int v = 0; v < NV; v++) begin
      wipe();
      src_lvl = VEC[v][1];
      wr(A_MASK, VEC[v][2]);
      pulse(VEC[v][0]);
      if (VEC[v][3] != 0) wr(A_CLR, VEC[v][3]);
      rd(A_RAW);  check($sformatf("R1/R3 vec%0d raw", v), rdata, VEC[v][4]);
      rd(A_MSKD); check($sformatf("R8 vec%0d masked", v), rdata, VEC[v][5]);
      check($sformatf("R9 vec%0d irq", v), {31'b0, irq}, VEC[v][6]);
    end

    // R5 event and clear in the same cycle
    wipe();
    @(negedge clk); src_evt = 32'h0100_0000; bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = 32'h0100_0000;
    @(negedge clk); src_evt = '0; bus_wr = 1'b0; bus_wdata = '0;
    rd(A_RAW); check("R5 set wins", rdata, 32'h0100_0000);

    // R3 sticky bit persists, zeros in clear leave it
    repeat (5) @(negedge clk);
    wr(A_CLR, 32'h0200_0000);
    rd(A_RAW); check("R3 hold after unrelated clear", rdata, 32'h0100_0000);
    // R4 write-one clears
    wr(A_CLR, 32'h0100_0000);
    rd(A_RAW); check("R4 cleared", rdata, 32'h0);

    // R10 read-only offsets ignore writes, clear reads zero, unmapped reads zero
    wipe();
    wr(A_RAW, 32'hFFFF_FFFF);
    wr(A_MSKD, 32'hFFFF_FFFF);
    rd(A_RAW);  check("R10 raw write ignored", rdata, 32'h0);
    rd(A_MASK); check("R10 masked write ignored", rdata, 32'h0);
    pulse(32'h0000_0008);
    rd(A_CLR);  check("R10 clear reads zero", rdata, 32'h0);
    rd(8'h3C);  check("R10 unmapped reads zero", rdata, 32'h0);

    // R6 reserved and unimplemented mask bits
    wr(A_MASK, 32'hFFFF_FFFF);
    rd(A_MASK); check("R6 mask readback", rdata, 32'h131F_007F);

    // R7 variant without bit 28
    wipe();
    pulse(32'h1000_0000);
    rd(A_RAW);  check("R7 bit28 present", rdata, 32'h1000_0000);
    check("R7 variant raw bit28 ignored", rdata_nw, 32'h0);
    wr(A_MASK, 32'hFFFF_FFFF);
    rd(A_MASK); check("R7 variant mask readback", rdata_nw, 32'h031F_007F);
    check("R7 variant irq low", {31'b0, irq_nw}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule